// File: doc/BRIEF.md
# Dual-Convention Stack Pointer Engine

This block owns a 16-bit stack pointer and carries out push and pop operations of one byte or one 16-bit word through a byte-wide memory port. A surrounding controller raises a push or pop request together with a width select, and the engine produces the memory accesses. It moves the pointer and, for pops, returns the data with a one-cycle done strobe.

A mode input picks one of two stack conventions. In next-available mode (`stk_mode` = 0) the pointer names the first free byte: pushes write and then decrement, and pops read above the pointer. In last-used mode (`stk_mode` = 1) the pointer names the most recently written byte: pushes decrement first and then write, and pops read at the pointer. Words are stored big-endian. The pointer can be loaded directly while the engine is idle.

Top module: `stack_engine`

## Requirements
- R1: After reset, `sp` is 0x0000, `busy` and `done` are low, and neither `mem_we` nor `mem_re` is asserted.
- R2: When idle, a high `load` sets `sp` to `load_val` on the next clock edge and takes priority over a push or pop request in the same cycle. A `load` raised while `busy` is high is ignored.
- R3: In mode 0 a byte push writes `wdata[7:0]` at address SP and leaves SP−1.
- R4: In mode 0 a word push writes the word starting at SP−1 and leaves SP−2.
- R5: In mode 0 a pop reads starting at SP+1 and leaves SP+1 (byte) or SP+2 (word).
- R6: In mode 1 a byte push writes `wdata[7:0]` at SP−1 and leaves SP−1.
- R7: In mode 1 a word push writes the word starting at SP−2 and leaves SP−2.
- R8: In mode 1 a pop reads starting at SP and leaves SP+1 or SP+2.
- R9: A word occupies two consecutive access cycles: the high byte is at the start address and the low byte at start+1. `sp` takes its new value on the accepting edge. `done` pulses for one cycle right after the last access. Pop data is valid on `rdata` while `done` is high, and a byte pop is zero-extended.
- R10: All pointer and address arithmetic wraps modulo 2^16.
- R11: A request is accepted only when idle, and requests seen while `busy` is high are ignored. If push and pop are raised together, the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stk_mode | input | 1 | 0 next-available, 1 last-used |
| req_push | input | 1 | Push request |
| req_pop | input | 1 | Pop request |
| req_word | input | 1 | 1 for a 16-bit transfer, 0 for a byte |
| wdata | input | 16 | Push data (low byte used for byte pushes) |
| load | input | 1 | Load stack pointer |
| load_val | input | 16 | Value for load |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, combinational to `mem_addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| rdata | output | 16 | Pop result |
| sp | output | 16 | Current stack pointer |

## Verification
A request sampled at edge E0 updates `sp` at E0. The first memory access occupies the cycle after E0, and a word's second access occupies the cycle after that. `done` and the pop data follow one cycle after the final access, so a byte operation completes two cycles after E0 and a word operation three cycles after E0. The bench drives inputs and samples outputs on falling edges. It checks `sp` at the first falling edge after acceptance, records every access cycle until `done` is seen, and requires the access count to equal the number of cycles before `done`. A final sample one cycle later confirms that disturbing inputs held during the operation had no effect.

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stk_mode,
  input  logic          req_push,
  input  logic          req_pop,
  input  logic          req_word,
  input  logic [15:0]   wdata,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1} state_t;

  state_t        state;
  logic [AW-1:0] sp_q, addr_q;
  logic          wr_q, word_q, done_q;
  logic [15:0]   data_q, rd_q;

  logic          go, push_sel;
  logic [AW-1:0] start_addr, next_sp;

  assign go       = (state == S_IDLE) && !load && (req_push || req_pop);
  assign push_sel = req_push;

  always_comb begin
    if (push_sel) begin
      next_sp = req_word ? sp_q - TWO : sp_q - ONE;
      if (stk_mode) start_addr = next_sp;
      else          start_addr = req_word ? sp_q - ONE : sp_q;
    end else begin
      next_sp    = req_word ? sp_q + TWO : sp_q + ONE;
      start_addr = stk_mode ? sp_q : sp_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sp_q   <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      data_q <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (load) begin
            sp_q <= load_val;
          end else if (go) begin
            sp_q   <= next_sp;
            addr_q <= start_addr;
            wr_q   <= push_sel;
            word_q <= req_word;
            data_q <= wdata;
            state  <= S_BEAT0;
          end
        end
        S_BEAT0: begin
          if (!wr_q) begin
            if (word_q) rd_q[15:8] <= mem_rdata;
            else        rd_q       <= {8'h00, mem_rdata};
          end
          if (word_q) begin
            addr_q <= addr_q + ONE;
            state  <= S_BEAT1;
          end else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_BEAT1: begin
          if (!wr_q) rd_q[7:0] <= mem_rdata;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign mem_we    = busy && wr_q;
  assign mem_re    = busy && !wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = (state == S_BEAT0 && word_q) ? data_q[15:8] : data_q[7:0];
  assign done      = done_q;
  assign rdata     = rd_q;
  assign sp        = sp_q;
endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stk_mode,
  input logic          req_push,
  input logic          req_pop,
  input logic          req_word,
  input logic [15:0]   wdata,
  input logic          load,
  input logic [AW-1:0] load_val,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [7:0]    mem_wdata,
  input logic [7:0]    mem_rdata,
  input logic          busy,
  input logic          done,
  input logic [15:0]   rdata,
  input logic [AW-1:0] sp
);
  assert_idle_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  assert_load_sets_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load) |=> (sp == $past(load_val)));

  assert_na_push8_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && req_push && !req_word && !stk_mode) |=> (sp == $past(sp) - AW'(1)));

  assert_lu_push_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && req_push && stk_mode) |=> (mem_we && mem_addr == sp));

  assert_word_next_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load && (req_push || req_pop) && req_word) |=> ##1 (busy && mem_addr == $past(mem_addr) + AW'(1)));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_busy_holds_sp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sp));
endmodule

bind stack_engine stack_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_stack_engine.sv
module test_stack_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stk_mode = 1'b0, req_push = 1'b0, req_pop = 1'b0, req_word = 1'b0;
  logic [15:0] wdata = '0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] rdata, sp;

  logic [7:0] mem [0:255];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  stack_engine i_stack_engine (
    .clk(clk), .rst_n(rst_n), .stk_mode(stk_mode), .req_push(req_push), .req_pop(req_pop),
    .req_word(req_word), .wdata(wdata), .load(load), .load_val(load_val),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .rdata(rdata), .sp(sp)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_start(input logic m, p, w, input logic [15:0] s);
    if (p) return m ? (w ? s - 16'd2 : s - 16'd1) : (w ? s - 16'd1 : s);
    return m ? s : s + 16'd1;
  endfunction

  function automatic logic [15:0] exp_next(input logic p, w, input logic [15:0] s);
    if (p) return w ? s - 16'd2 : s - 16'd1;
    return w ? s + 16'd2 : s + 16'd1;
  endfunction

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sp == 16'h0000, "R1", "reset sp", sp, 16'h0000);
    check(!busy && !done, "R1", "reset busy/done", {busy, done}, 16'h0);
    check(!mem_we && !mem_re, "R1", "reset strobes", {mem_we, mem_re}, 16'h0);
  endtask

  task automatic do_load(input logic [15:0] v, input logic with_req);
    @(negedge clk);
    load = 1'b1; load_val = v; req_push = with_req; req_word = 1'b0;
    @(negedge clk);
    load = 1'b0; req_push = 1'b0;
    check(sp == v, "R2", "load sp", sp, v);
    check(!busy, "R2", "load over request stays idle", {15'd0, busy}, 16'h0);
  endtask

  task automatic run_op(input string tag, input logic m, p, w, input logic [15:0] d,
                        input logic [15:0] exp_rd, input bit disturb, input bit both);
    logic [15:0] sp0, nsp, base;
    logic [15:0] a [4];
    logic [7:0]  bd [4];
    logic        wr [4];
    int n, k;
    @(negedge clk);
    sp0 = sp;
    base = exp_start(m, p, w, sp0);
    nsp = exp_next(p, w, sp0);
    stk_mode = m; req_push = p; req_pop = !p || both; req_word = w; wdata = d;
    @(negedge clk);
    req_push = 1'b0; req_pop = 1'b0;
    if (disturb) begin
      req_pop = 1'b1; req_push = 1'b1; load = 1'b1; load_val = 16'hDEAD; wdata = 16'h7777;
    end
    check(sp == nsp, tag, "sp after accept", sp, nsp);
    n = 0; k = 0;
    while (!done && k < 8) begin
      if ((mem_we || mem_re) && n < 4) begin
        a[n] = mem_addr; bd[n] = mem_wdata; wr[n] = mem_we; n++;
      end
      k++;
      @(negedge clk);
    end
    req_push = 1'b0; req_pop = 1'b0; load = 1'b0;
    check(done && k == (w ? 2 : 1), "R9", "done cycle", 16'(k), w ? 16'd2 : 16'd1);
    check(n == (w ? 2 : 1), "R9", "access count", 16'(n), w ? 16'd2 : 16'd1);
    if (n >= 1) begin
      check(a[0] == base, tag, "first address", a[0], base);
      check(wr[0] == p, tag, "access kind", {15'd0, wr[0]}, {15'd0, p});
      if (p) check(bd[0] == (w ? d[15:8] : d[7:0]), "R9", "first byte",
                   {8'd0, bd[0]}, {8'd0, w ? d[15:8] : d[7:0]});
    end
    if (w && n >= 2) begin
      check(a[1] == base + 16'd1, "R9", "second address", a[1], base + 16'd1);
      if (p) check(bd[1] == d[7:0], "R9", "low byte", {8'd0, bd[1]}, {8'd0, d[7:0]});
    end
    if (!p) check(rdata == exp_rd, tag, "pop data", rdata, exp_rd);
    @(negedge clk);
    check(sp == nsp && !busy, disturb ? "R11" : tag, "sp settled", sp, nsp);
  endtask

  task automatic test_next_available;
    do_load(16'h0100, 1'b0);
    run_op("R3", 1'b0, 1'b1, 1'b0, 16'h00A5, 16'h0, 0, 0);
    run_op("R4", 1'b0, 1'b1, 1'b1, 16'h1234, 16'h0, 0, 0);
    run_op("R5", 1'b0, 1'b0, 1'b1, 16'h0, 16'h1234, 0, 0);
    run_op("R5", 1'b0, 1'b0, 1'b0, 16'h0, 16'h00A5, 0, 0);
  endtask

  task automatic test_last_used;
    do_load(16'h0080, 1'b0);
    run_op("R6", 1'b1, 1'b1, 1'b0, 16'h005A, 16'h0, 0, 0);
    run_op("R7", 1'b1, 1'b1, 1'b1, 16'hBEEF, 16'h0, 0, 0);
    run_op("R8", 1'b1, 1'b0, 1'b1, 16'h0, 16'hBEEF, 0, 0);
    run_op("R8", 1'b1, 1'b0, 1'b0, 16'h0, 16'h005A, 0, 0);
  endtask

  task automatic test_wrap;
    do_load(16'h0000, 1'b0);
    run_op("R10", 1'b0, 1'b1, 1'b1, 16'hCAFE, 16'h0, 0, 0);
    run_op("R10", 1'b0, 1'b0, 1'b1, 16'h0, 16'hCAFE, 0, 0);
    do_load(16'h0001, 1'b0);
    run_op("R10", 1'b1, 1'b1, 1'b1, 16'h9137, 16'h0, 0, 0);
    run_op("R10", 1'b1, 1'b0, 1'b1, 16'h0, 16'h9137, 0, 0);
  endtask

  task automatic test_busy_and_priority;
    do_load(16'h0040, 1'b1);
    run_op("R11", 1'b0, 1'b1, 1'b1, 16'h4321, 16'h0, 1, 0);
    run_op("R11", 1'b0, 1'b1, 1'b0, 16'h0066, 16'h0, 0, 1);
    run_op("R11", 1'b0, 1'b0, 1'b0, 16'h0, 16'h0066, 1, 0);
    run_op("R11", 1'b0, 1'b0, 1'b1, 16'h0, 16'h4321, 0, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    test_reset;
    test_next_available;
    test_last_used;
    test_wrap;
    test_busy_and_priority;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule